// File: doc/BRIEF.md
# SDRAM Write-Termination Command Sequencer

This block sits on the controller side of an SDRAM. It takes one write request at a time and drives a single bank through the full write. It opens the row and waits out the activate-to-column delay. It then issues the write command, marks every data beat, and closes the row in one of two ways. The first is a single-bank precharge issued after the write-recovery delay. The second is a write with auto-precharge, after which the block sends only no-operation commands until the bank may be opened again.

The request carries a bank, a row, a column, a burst-length code and an auto-precharge flag. The three timing values (activate-to-write, write recovery, precharge recovery) are given as cycle counts on configuration inputs. They are captured at the moment a request is accepted. All command, address and mask outputs are registered. The `wr_beat` output marks the cycles in which the data path must present a write word. The block works out for itself when the masking window opens and closes and when `req_ready` may rise again.

Top module: `sdram_wrterm_seq`

## Requirements
- R1: After reset, `req_ready` is 1, the command pins read NOP ({ras_n,cas_n,we_n} = 3'b111), and `sd_dqm` and `wr_beat` are 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. In the next cycle the pins carry ACTIVATE (3'b011), with the row on `sd_addr` and the bank on `sd_ba`. `req_ready` then stays 0 until the sequence is over, so one handshake starts exactly one sequence, and a `req_valid` held high starts nothing more. While the block is idle, `req_ready` stays 1.
- R3: The WRITE command (3'b100) follows ACTIVATE after trcd cycles, with the column on `sd_addr[COL_W-1:0]`. `wr_beat` is 1 from the WRITE cycle on for as many cycles as the burst has words. Burst codes: 0 gives 1 word, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives a full page of 2**COL_W words.
- R4: Without auto-precharge, PRECHARGE (3'b010) with `sd_addr[10]` = 0 (single bank) and the bank on `sd_ba` is issued exactly twr cycles after the cycle of the last data word.
- R5: On the precharge ending, bursts of 4, 8 or a full page drive `sd_dqm` to 1 from the cycle after the last data word up to and including the PRECHARGE cycle. Bursts of 1 or 2 keep `sd_dqm` at 0 throughout. `sd_dqm` is never 1 while `wr_beat` is 1.
- R6: With auto-precharge on a burst that is not full page, the WRITE carries `sd_addr[10]` = 1. From then on only NOP is issued. `req_ready` first rises in the cycle (BL-1)+twr+trp-1 after the WRITE, so the earliest next ACTIVATE comes (BL-1)+twr+trp cycles after the WRITE.
- R7: Without auto-precharge, `req_ready` first rises trp-1 cycles after the PRECHARGE, so the next ACTIVATE comes no earlier than trp cycles after it.
- R8: For a full-page burst the auto-precharge flag is ignored. The WRITE carries `sd_addr[10]` = 0, and the sequence ends with an explicit precharge and masking as in R4, R5 and R7.
- R9: Every cycle that carries no ACTIVATE, WRITE or PRECHARGE carries NOP, and no other command encoding ever appears.
- R10: The reserved burst codes 4, 5 and 6 behave as a single-word burst.
- R11: The timing inputs are sampled only at acceptance, so changing them during a sequence does not alter it. Sampled values below the minimum are raised to it: trcd and twr to 1, trp to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept the next request |
| req_bank | input | BA_W | Target bank |
| req_row | input | ADDR_W | Row to open |
| req_col | input | COL_W | Starting column |
| req_blen | input | 3 | Burst-length code |
| req_autopre | input | 1 | End the write with auto-precharge |
| cfg_trcd | input | TW_W | Activate-to-write delay in cycles |
| cfg_twr | input | TW_W | Write recovery in cycles |
| cfg_trp | input | TW_W | Precharge recovery in cycles |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | ADDR_W | Row/column address, bit 10 is the precharge qualifier |
| sd_dqm | output | 1 | Data mask |
| wr_beat | output | 1 | A write data word is due in this cycle |

## Verification
The hardest case to reach from the ports is a full-page request with the auto-precharge flag set. Here the flag must be dropped: the WRITE must go out with bit 10 low, and the sequence must fall back to masked explicit precharge after a 512-word burst. The bench issues exactly that request and checks every cycle of the run. A second hard case is a timing input that changes while a sequence is under way. Another request holds `req_valid` high past its handshake and rewrites all three timing inputs straight after acceptance, while the scoreboard still expects the timing captured at acceptance. Timing inputs of zero are applied too, so that the clamped minimum path with no wait states is exercised.

// File: rtl/sdram_wrterm_pkg.sv
package sdram_wrterm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT,
    ST_RCD,
    ST_WR,
    ST_BURST,
    ST_REC,
    ST_PRE,
    ST_RP
  } seq_state_e;

  // {ras_n, cas_n, we_n}
  localparam logic [2:0] CMD_NOP   = 3'b111;
  localparam logic [2:0] CMD_ACT   = 3'b011;
  localparam logic [2:0] CMD_WRITE = 3'b100;
  localparam logic [2:0] CMD_PRE   = 3'b010;

endpackage

// File: rtl/sdram_wrterm_len.sv
module sdram_wrterm_len #(
  parameter int COL_W = 9
) (
  input  logic [2:0]     code,
  output logic [COL_W:0] beats,
  output logic           full_page,
  output logic           mask_tail
);

  localparam logic [COL_W:0] ONE = (COL_W+1)'(1);

  always_comb begin
    unique case (code)
      3'd0:    beats = ONE;
      3'd1:    beats = ONE << 1;
      3'd2:    beats = ONE << 2;
      3'd3:    beats = ONE << 3;
      3'd7:    beats = ONE << COL_W;
      default: beats = ONE;
    endcase
  end

  assign full_page = (code == 3'd7);
  assign mask_tail = (code == 3'd2) || (code == 3'd3) || (code == 3'd7);

endmodule

// File: rtl/sdram_wrterm_fsm.sv
module sdram_wrterm_fsm
  import sdram_wrterm_pkg::*;
#(
  parameter int BA_W   = 2,
  parameter int ADDR_W = 13,
  parameter int COL_W  = 9,
  parameter int TW_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hs,
  input  logic [BA_W-1:0]   req_bank,
  input  logic [ADDR_W-1:0] req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_ap,
  input  logic              req_mask,
  input  logic [COL_W:0]    req_beats,
  input  logic [TW_W-1:0]   cfg_trcd,
  input  logic [TW_W-1:0]   cfg_twr,
  input  logic [TW_W-1:0]   cfg_trp,
  output seq_state_e        st_n,
  output logic [BA_W-1:0]   bank_n,
  output logic [ADDR_W-1:0] row_n,
  output logic [COL_W-1:0]  col_n,
  output logic              ap_n,
  output logic              mask_n
);

  localparam int CNT_W = ((COL_W + 1) > (TW_W + 2)) ? (COL_W + 1) : (TW_W + 2);
  localparam logic [TW_W-1:0] T1 = TW_W'(1);
  localparam logic [TW_W-1:0] T2 = TW_W'(2);

  seq_state_e        st_q;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BA_W-1:0]   bank_q;
  logic [ADDR_W-1:0] row_q;
  logic [COL_W-1:0]  col_q;
  logic              ap_q, mask_q;
  logic [COL_W:0]    beats_q;
  logic [TW_W-1:0]   trcd_q, twr_q, trp_q;
  logic [TW_W-1:0]   trcd_c, twr_c, trp_c;
  logic              ld, go_tail;

  assign ld     = hs && (st_q == ST_IDLE);
  assign trcd_c = (cfg_trcd < T1) ? T1 : cfg_trcd;
  assign twr_c  = (cfg_twr  < T1) ? T1 : cfg_twr;
  assign trp_c  = (cfg_trp  < T2) ? T2 : cfg_trp;

  assign bank_n = ld ? req_bank : bank_q;
  assign row_n  = ld ? req_row  : row_q;
  assign col_n  = ld ? req_col  : col_q;
  assign ap_n   = ld ? req_ap   : ap_q;
  assign mask_n = ld ? req_mask : mask_q;

  always_comb begin
    st_n    = st_q;
    cnt_n   = cnt_q;
    go_tail = 1'b0;
    unique case (st_q)
      ST_IDLE: if (hs) st_n = ST_ACT;
      ST_ACT: begin
        if (trcd_q == T1) st_n = ST_WR;
        else begin
          st_n  = ST_RCD;
          cnt_n = CNT_W'(trcd_q) - CNT_W'(2);
        end
      end
      ST_RCD: begin
        if (cnt_q == '0) st_n = ST_WR;
        else cnt_n = cnt_q - CNT_W'(1);
      end
      ST_WR: begin
        if (beats_q == (COL_W+1)'(1)) go_tail = 1'b1;
        else begin
          st_n  = ST_BURST;
          cnt_n = CNT_W'(beats_q) - CNT_W'(2);
        end
      end
      ST_BURST: begin
        if (cnt_q == '0) go_tail = 1'b1;
        else cnt_n = cnt_q - CNT_W'(1);
      end
      ST_REC: begin
        if (cnt_q == '0) st_n = ST_PRE;
        else cnt_n = cnt_q - CNT_W'(1);
      end
      ST_PRE: begin
        if (trp_q == T2) st_n = ST_IDLE;
        else begin
          st_n  = ST_RP;
          cnt_n = CNT_W'(trp_q) - CNT_W'(3);
        end
      end
      ST_RP: begin
        if (cnt_q == '0) st_n = ST_IDLE;
        else cnt_n = cnt_q - CNT_W'(1);
      end
      default: st_n = ST_IDLE;
    endcase
    if (go_tail) begin
      if (ap_q) begin
        st_n  = ST_RP;
        cnt_n = CNT_W'(twr_q) + CNT_W'(trp_q) - CNT_W'(3);
      end else if (twr_q == T1) begin
        st_n = ST_PRE;
      end else begin
        st_n  = ST_REC;
        cnt_n = CNT_W'(twr_q) - CNT_W'(2);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      bank_q  <= '0;
      row_q   <= '0;
      col_q   <= '0;
      ap_q    <= 1'b0;
      mask_q  <= 1'b0;
      beats_q <= (COL_W+1)'(1);
      trcd_q  <= T1;
      twr_q   <= T1;
      trp_q   <= T2;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      if (ld) begin
        bank_q  <= req_bank;
        row_q   <= req_row;
        col_q   <= req_col;
        ap_q    <= req_ap;
        mask_q  <= req_mask;
        beats_q <= req_beats;
        trcd_q  <= trcd_c;
        twr_q   <= twr_c;
        trp_q   <= trp_c;
      end
    end
  end

endmodule

// File: rtl/sdram_wrterm_pins.sv
module sdram_wrterm_pins
  import sdram_wrterm_pkg::*;
#(
  parameter int BA_W   = 2,
  parameter int ADDR_W = 13,
  parameter int COL_W  = 9,
  parameter int AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_state_e        st_n,
  input  logic [BA_W-1:0]   bank_n,
  input  logic [ADDR_W-1:0] row_n,
  input  logic [COL_W-1:0]  col_n,
  input  logic              ap_n,
  input  logic              mask_n,
  output logic              ready,
  output logic [2:0]        cmd,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              dqm,
  output logic              beat
);

  logic              ready_d, dqm_d, beat_d;
  logic [2:0]        cmd_d;
  logic [BA_W-1:0]   ba_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    ready_d = 1'b0;
    cmd_d   = CMD_NOP;
    ba_d    = '0;
    addr_d  = '0;
    dqm_d   = 1'b0;
    beat_d  = 1'b0;
    unique case (st_n)
      ST_IDLE: ready_d = 1'b1;
      ST_ACT: begin
        cmd_d  = CMD_ACT;
        ba_d   = bank_n;
        addr_d = row_n;
      end
      ST_WR: begin
        cmd_d                  = CMD_WRITE;
        ba_d                   = bank_n;
        addr_d[COL_W-1:0]      = col_n;
        addr_d[AP_BIT]         = ap_n;
        beat_d                 = 1'b1;
      end
      ST_BURST: beat_d = 1'b1;
      ST_REC:   dqm_d  = mask_n;
      ST_PRE: begin
        cmd_d = CMD_PRE;
        ba_d  = bank_n;
        dqm_d = mask_n;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ready <= 1'b1;
      cmd   <= CMD_NOP;
      ba    <= '0;
      addr  <= '0;
      dqm   <= 1'b0;
      beat  <= 1'b0;
    end else begin
      ready <= ready_d;
      cmd   <= cmd_d;
      ba    <= ba_d;
      addr  <= addr_d;
      dqm   <= dqm_d;
      beat  <= beat_d;
    end
  end

endmodule

// File: rtl/sdram_wrterm_seq.sv
module sdram_wrterm_seq
  import sdram_wrterm_pkg::*;
#(
  parameter int BA_W   = 2,
  parameter int ADDR_W = 13,
  parameter int COL_W  = 9,
  parameter int TW_W   = 4,
  parameter int AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BA_W-1:0]   req_bank,
  input  logic [ADDR_W-1:0] req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [2:0]        req_blen,
  input  logic              req_autopre,
  input  logic [TW_W-1:0]   cfg_trcd,
  input  logic [TW_W-1:0]   cfg_twr,
  input  logic [TW_W-1:0]   cfg_trp,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              sd_dqm,
  output logic              wr_beat
);

  logic [COL_W:0]    beats;
  logic              full_page, mask_tail, ap_eff, mask_eff, hs;
  seq_state_e        st_n;
  logic [BA_W-1:0]   bank_n;
  logic [ADDR_W-1:0] row_n;
  logic [COL_W-1:0]  col_n;
  logic              ap_n, mask_n;
  logic [2:0]        cmd;

  assign hs       = req_valid && req_ready;
  assign ap_eff   = req_autopre && !full_page;
  assign mask_eff = mask_tail && !ap_eff;

  sdram_wrterm_len #(.COL_W(COL_W)) u_len (
    .code      (req_blen),
    .beats     (beats),
    .full_page (full_page),
    .mask_tail (mask_tail)
  );

  sdram_wrterm_fsm #(
    .BA_W(BA_W), .ADDR_W(ADDR_W), .COL_W(COL_W), .TW_W(TW_W)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .hs        (hs),
    .req_bank  (req_bank),
    .req_row   (req_row),
    .req_col   (req_col),
    .req_ap    (ap_eff),
    .req_mask  (mask_eff),
    .req_beats (beats),
    .cfg_trcd  (cfg_trcd),
    .cfg_twr   (cfg_twr),
    .cfg_trp   (cfg_trp),
    .st_n      (st_n),
    .bank_n    (bank_n),
    .row_n     (row_n),
    .col_n     (col_n),
    .ap_n      (ap_n),
    .mask_n    (mask_n)
  );

  sdram_wrterm_pins #(
    .BA_W(BA_W), .ADDR_W(ADDR_W), .COL_W(COL_W), .AP_BIT(AP_BIT)
  ) u_pins (
    .clk    (clk),
    .rst    (rst),
    .st_n   (st_n),
    .bank_n (bank_n),
    .row_n  (row_n),
    .col_n  (col_n),
    .ap_n   (ap_n),
    .mask_n (mask_n),
    .ready  (req_ready),
    .cmd    (cmd),
    .ba     (sd_ba),
    .addr   (sd_addr),
    .dqm    (sd_dqm),
    .beat   (wr_beat)
  );

  assign sd_ras_n = cmd[2];
  assign sd_cas_n = cmd[1];
  assign sd_we_n  = cmd[0];

endmodule

// File: rtl/sdram_wrterm_chk.sv
module sdram_wrterm_chk
  import sdram_wrterm_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int AP_BIT = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic              dqm,
  input logic              beat
);

  logic [2:0] cmd;
  logic       ap_pend;

  assign cmd = {ras_n, cas_n, we_n};

  always_ff @(posedge clk) begin
    if (rst)                                       ap_pend <= 1'b0;
    else if (req_ready)                            ap_pend <= 1'b0;
    else if (cmd == CMD_WRITE && addr[AP_BIT])     ap_pend <= 1'b1;
  end

  AST_ACCEPT_OPENS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (cmd == CMD_ACT && !req_ready)); // R2
  AST_ACT_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_ACT) |-> !req_ready); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (cmd == CMD_NOP && !dqm && !beat)); // R9
  AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_NOP || cmd == CMD_ACT || cmd == CMD_WRITE || cmd == CMD_PRE)); // R9
  AST_WRITE_BEAT: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_WRITE) |-> beat); // R3
  AST_BEAT_UNMASKED: assert property (@(posedge clk) disable iff (rst)
    beat |-> !dqm); // R5
  AST_PRE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_PRE) |-> !addr[AP_BIT]); // R4
  AST_AUTO_NO_PRE: assert property (@(posedge clk) disable iff (rst)
    ap_pend |-> (cmd != CMD_PRE && cmd != CMD_WRITE)); // R6

endmodule

bind sdram_wrterm_seq sdram_wrterm_chk #(.ADDR_W(ADDR_W), .AP_BIT(AP_BIT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .ras_n     (sd_ras_n),
  .cas_n     (sd_cas_n),
  .we_n      (sd_we_n),
  .addr      (sd_addr),
  .dqm       (sd_dqm),
  .beat      (wr_beat)
);

// File: tb/sim_sdram_wrterm_seq.sv
`timescale 1ns/100ps
module sim_sdram_wrterm_seq;

  localparam int BA_W = 2, ADDR_W = 13, COL_W = 9, TW_W = 4;
  localparam logic [2:0] NOP = 3'b111, ACT = 3'b011, WRT = 3'b100, PRE = 3'b010;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_autopre = 1'b0;
  logic [BA_W-1:0]   req_bank = '0;
  logic [ADDR_W-1:0] req_row = '0;
  logic [COL_W-1:0]  req_col = '0;
  logic [2:0]        req_blen = '0;
  logic [TW_W-1:0]   cfg_trcd = 4'd2, cfg_twr = 4'd2, cfg_trp = 4'd2;
  logic req_ready, sd_ras_n, sd_cas_n, sd_we_n, sd_dqm, wr_beat;
  logic [BA_W-1:0]   sd_ba;
  logic [ADDR_W-1:0] sd_addr;

  int cyc = 0, n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdram_wrterm_seq u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_blen(req_blen),
    .req_autopre(req_autopre), .cfg_trcd(cfg_trcd), .cfg_twr(cfg_twr), .cfg_trp(cfg_trp),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
    .sd_addr(sd_addr), .sd_dqm(sd_dqm), .wr_beat(wr_beat)
  );

  typedef struct {
    int                cyc;
    logic [2:0]        cmd;
    logic [BA_W-1:0]   ba;
    logic [ADDR_W-1:0] addr;
    logic [ADDR_W-1:0] amask;
    logic              dqm;
    logic              beat;
    logic              rdy;
    string             tag;
  } exp_t;

  exp_t sb[$];
  exp_t mon_e;

  task automatic push(input int c, input logic [2:0] cmd, input logic [BA_W-1:0] ba,
                      input logic [ADDR_W-1:0] addr, input logic [ADDR_W-1:0] amask,
                      input logic dqm, input logic beat, input logic rdy, input string tag);
    exp_t e;
    e.cyc = c; e.cmd = cmd; e.ba = ba; e.addr = addr; e.amask = amask;
    e.dqm = dqm; e.beat = beat; e.rdy = rdy; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compares one expected item per cycle, away from the rising edge
  always @(negedge clk) begin
    if (!rst && sb.size() > 0 && sb[0].cyc == cyc) begin
      mon_e = sb.pop_front();
      n_chk++;
      if ({sd_ras_n, sd_cas_n, sd_we_n} != mon_e.cmd || sd_dqm != mon_e.dqm ||
          wr_beat != mon_e.beat || req_ready != mon_e.rdy ||
          (sd_addr & mon_e.amask) != (mon_e.addr & mon_e.amask) ||
          (mon_e.cmd != NOP && sd_ba != mon_e.ba)) begin
        n_bad++;
        $display("FAIL %s cyc=%0d got cmd=%b ba=%0d addr=%h dqm=%b beat=%b rdy=%b exp cmd=%b ba=%0d addr=%h/%h dqm=%b beat=%b rdy=%b",
          mon_e.tag, cyc, {sd_ras_n, sd_cas_n, sd_we_n}, sd_ba, sd_addr, sd_dqm, wr_beat, req_ready,
          mon_e.cmd, mon_e.ba, mon_e.addr, mon_e.amask, mon_e.dqm, mon_e.beat, mon_e.rdy);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic run_req(input logic [BA_W-1:0] bk, input logic [ADDR_W-1:0] row,
                         input logic [COL_W-1:0] col, input logic [2:0] code, input logic ap,
                         input int trcd, input int twr, input int trp,
                         input bit hold, input bit scramble, input string tag);
    int c, a, w, l, p, beats, te, we, pe;
    bit full, ape, msk;
    logic [ADDR_W-1:0] wa;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    c     = cyc;
    full  = (code == 3'd7);
    beats = (code <= 3'd3) ? (1 << code) : (full ? (1 << COL_W) : 1);
    ape   = ap && !full;
    msk   = (code == 3'd2 || code == 3'd3 || full) && !ape;
    te = (trcd < 1) ? 1 : trcd;
    we = (twr  < 1) ? 1 : twr;
    pe = (trp  < 2) ? 2 : trp;
    req_bank = bk; req_row = row; req_col = col; req_blen = code; req_autopre = ap;
    cfg_trcd = TW_W'(trcd); cfg_twr = TW_W'(twr); cfg_trp = TW_W'(trp);
    req_valid = 1'b1;
    a = c + 1;
    push(a, ACT, bk, row, '1, 0, 0, 0, tag);
    for (int i = 1; i < te; i++) push(a + i, NOP, '0, '0, '0, 0, 0, 0, tag);
    w  = a + te;
    wa = '0; wa[COL_W-1:0] = col; wa[10] = ape;
    push(w, WRT, bk, wa, 13'h05FF, 0, 1, 0, tag);
    for (int i = 1; i < beats; i++) push(w + i, NOP, '0, '0, '0, 0, 1, 0, tag);
    l = w + beats - 1;
    if (ape) begin
      for (int i = 1; i <= we + pe - 2; i++) push(l + i, NOP, '0, '0, '0, 0, 0, 0, tag);
      push(l + we + pe - 1, NOP, '0, '0, '0, 0, 0, 1, tag);
    end else begin
      for (int i = 1; i < we; i++) push(l + i, NOP, '0, '0, '0, msk, 0, 0, tag);
      p = l + we;
      push(p, PRE, bk, '0, 13'h0400, msk, 0, 0, tag);
      for (int i = 1; i <= pe - 2; i++) push(p + i, NOP, '0, '0, '0, 0, 0, 0, tag);
      push(p + pe - 1, NOP, '0, '0, '0, 0, 0, 1, tag);
    end
    @(posedge clk); #1;
    if (scramble) begin
      cfg_trcd = 4'd15; cfg_twr = 4'd13; cfg_trp = 4'd11;
    end
    if (hold) begin
      @(posedge clk); #1;
    end
    req_valid = 1'b0;
    while (sb.size() > 0) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired, %0d items pending", sb.size());
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk({sd_ras_n, sd_cas_n, sd_we_n} == NOP, "R1 nop after reset", {sd_ras_n, sd_cas_n, sd_we_n}, NOP);
    chk(!sd_dqm && !wr_beat, "R1 dqm/beat after reset", {sd_dqm, wr_beat}, 0);
    #1 rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(req_ready == 1'b1, "R2 ready while idle", req_ready, 1);

    run_req(2'd1, 13'h1A5C, 9'h0F3, 3'd2, 1'b0, 2, 2, 3, 0, 0, "R4 R5 R7 bl4 precharge");
    run_req(2'd2, 13'h0123, 9'h1FF, 3'd0, 1'b0, 3, 3, 4, 0, 0, "R5 bl1 unmasked");
    run_req(2'd3, 13'h1FFF, 9'h001, 3'd1, 1'b0, 1, 1, 2, 0, 0, "R3 R9 bl2 min timing");
    run_req(2'd0, 13'h0AAA, 9'h155, 3'd3, 1'b0, 2, 3, 2, 0, 0, "R5 bl8 masked");
    run_req(2'd1, 13'h0555, 9'h0AA, 3'd2, 1'b1, 2, 2, 3, 0, 0, "R6 bl4 autoprecharge");
    run_req(2'd2, 13'h1357, 9'h0C0, 3'd0, 1'b1, 1, 4, 5, 0, 0, "R6 bl1 autoprecharge");
    run_req(2'd3, 13'h0F0F, 9'h000, 3'd7, 1'b1, 3, 2, 3, 0, 0, "R8 full page ap ignored");
    run_req(2'd0, 13'h0777, 9'h077, 3'd5, 1'b0, 2, 2, 2, 0, 0, "R10 reserved code");
    run_req(2'd1, 13'h0321, 9'h123, 3'd6, 1'b1, 2, 1, 2, 0, 0, "R10 reserved auto");
    run_req(2'd2, 13'h1111, 9'h0FE, 3'd3, 1'b0, 3, 2, 3, 1, 1, "R11 R2 cfg change held valid");
    run_req(2'd3, 13'h0808, 9'h080, 3'd2, 1'b0, 0, 0, 0, 0, 0, "R11 zero cfg clamp");
    run_req(2'd0, 13'h0404, 9'h040, 3'd1, 1'b1, 0, 0, 0, 0, 0, "R11 R6 zero cfg auto");

    repeat (3) begin
      @(negedge clk);
      chk(req_ready == 1'b1 && {sd_ras_n, sd_cas_n, sd_we_n} == NOP, "R2 R9 idle after runs",
          {req_ready, sd_ras_n, sd_cas_n, sd_we_n}, {1'b1, NOP});
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule